// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Holding Buffer

This block receives asynchronous serial frames on a single line input. The frame has an idle-high line, one low start bit, then eight or nine data bits sent least significant bit first, then one high stop bit. Every bit time is divided into a fixed number of oversampling ticks. Three ticks near the middle of each bit are sampled, and the bit value is the majority of those three samples. A short low pulse that is gone by mid-bit is treated as noise and does not start a frame.

Completed frames go into a two-entry holding buffer. Each entry keeps its data byte, its ninth bit and its framing-error flag together. The host always sees the oldest entry at the outputs, together with an available flag that can drive an interrupt line. Asserting the read strobe for one cycle removes that entry. If a frame completes while both entries are occupied, that frame is dropped and a sticky overrun flag is raised. The only way to clear the overrun flag is to drop the receive enable and then raise it again. Dropping the enable also returns the frame logic to idle.

Top module: `uart_rx_buf`

## Requirements
- R1: An oversampling tick occurs once every `div_i`+1 clock cycles. One bit time is 16 ticks. A frame is a low start bit, then the data bits with bit 0 first, then a stop bit. The byte appears on `data_o` with bit 0 holding the first data bit received.
- R2: Each bit value is the majority of three line samples taken at ticks 7, 8 and 9 of that bit. A line disturbance of one clock cycle inside a bit does not change the received value.
- R3: A low level on the idle line is only accepted as a start bit if the majority of its mid-bit samples is low. Otherwise the receiver goes back to idle, and no entry is stored.
- R4: When `nine_bit_i` is 1 at the start of a frame, nine data bits are received and the ninth one appears on `bit9_o`. When it is 0, eight bits are received and the stored `bit9_o` is 0.
- R5: If the stop bit majority is low, the frame is still stored, and its entry shows `ferr_o`=1. A high stop bit gives `ferr_o`=0.
- R6: `avail_o` is 1 whenever at least one entry is held. `data_o`, `bit9_o` and `ferr_o` show the oldest entry and do not change while `avail_o` is 1 and `rd_i` is 0.
- R7: A cycle with `rd_i`=1 and `avail_o`=1 removes the oldest entry. If a second entry was held, `avail_o` stays 1 and that entry appears at the outputs. A read while the buffer is empty has no effect.
- R8: If a frame completes while both entries are held, it is discarded and `ovr_o` becomes 1. Both held entries can still be read, in arrival order.
- R9: Once set, `ovr_o` stays at 1 while `rx_en_i` is 1, and it clears in the cycle after `rx_en_i` is 0. While `rx_en_i` is 0, the line is ignored and no entry is added, but entries already held stay readable.
- R10: After reset, `avail_o`, `ovr_o`, `data_o`, `bit9_o` and `ferr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Continuous receive enable; low resets frame logic and overrun |
| nine_bit_i | input | 1 | Select nine data bits per frame |
| div_i | input | 8 | Oversampling tick divider (tick every div_i+1 cycles) |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| avail_o | output | 1 | At least one entry held (interrupt request) |
| data_o | output | 8 | Data byte of oldest entry |
| bit9_o | output | 1 | Ninth bit of oldest entry |
| ferr_o | output | 1 | Framing error of oldest entry |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Several properties are checked on every cycle: the overrun flag holds while receive is enabled and clears after a disable, it only rises while an entry is held, the head outputs and the available flag stay steady when there is no read, and nothing becomes available while the receiver is disabled. The following only show up in the bench's scenarios: the bit order, majority voting under one-cycle disturbances, start-glitch rejection, nine-bit capture, framing-error flagging, the divider's effect on timing, and the ordering of the two held entries around an overrun.

// File: rtl/uart_rx_buf_pkg.sv
package uart_rx_buf_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rx_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == div_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == div_i);
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OSR  = 16,
  parameter int PH_W = $clog2(OSR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            din_i,
  output logic            vote_o
);
  localparam int MID = OSR / 2;
  localparam logic [PH_W-1:0] PH_LO  = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_HI  = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OSR - 1);

  logic [1:0] ones_q;
  logic       in_win;
  logic [2:0] sum;

  assign in_win = (phase_i >= PH_LO) && (phase_i <= PH_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ones_q <= '0;
    else if (clr_i || (tick_i && phase_i == PH_END)) ones_q <= '0;
    else if (tick_i && in_win && din_i)        ones_q <= ones_q + 1'b1;
  end

  // third sample joins combinationally at the decision tick
  assign sum    = {1'b0, ones_q} + {2'b00, (tick_i && in_win && din_i)};
  assign vote_o = (sum >= 3'd2);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_buf_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int PH_W = $clog2(OSR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            rxd_i,
  input  logic            nine_i,
  input  logic            vote_i,
  output logic [PH_W-1:0] phase_o,
  output logic            idle_o,
  output logic            frame_vld_o,
  output rx_entry_t       frame_o
);
  localparam logic [PH_W-1:0] PH_DEC = PH_W'(OSR / 2 + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OSR - 1);
  localparam int SH_W = DATA_W + 1;

  rx_state_e        state_q;
  logic [PH_W-1:0]  phase_q;
  logic [3:0]       bit_q;
  logic [SH_W-1:0]  sh_q;
  logic             nine_q;
  logic             vld_q;
  rx_entry_t        frame_q;
  logic             dec, bend;
  logic [3:0]       last_bit;
  logic [PH_W-1:0]  phase_nxt;

  assign dec       = tick_i && (phase_q == PH_DEC);
  assign bend      = tick_i && (phase_q == PH_END);
  assign last_bit  = nine_q ? 4'(DATA_W) : 4'(DATA_W - 1);
  assign phase_nxt = (phase_q == PH_END) ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      vld_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        phase_q <= '0;
      end else begin
        if (state_q != ST_IDLE && tick_i) phase_q <= phase_nxt;
        unique case (state_q)
          ST_IDLE: begin
            if (tick_i && !rxd_i) begin
              state_q <= ST_START;
              phase_q <= '0;
              bit_q   <= '0;
              nine_q  <= nine_i;
            end
          end
          ST_START: begin
            if (dec && vote_i)  state_q <= ST_IDLE;  // glitch, not a start
            else if (bend)      state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (dec) sh_q <= {vote_i, sh_q[SH_W-1:1]};
            if (bend) begin
              if (bit_q == last_bit) state_q <= ST_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (dec) begin
              state_q      <= ST_IDLE;
              vld_q        <= 1'b1;
              frame_q.data <= nine_q ? sh_q[DATA_W-1:0] : sh_q[SH_W-1:1];
              frame_q.bit9 <= nine_q & sh_q[SH_W-1];
              frame_q.ferr <= !vote_i;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign phase_o     = phase_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign frame_vld_o = vld_q;
  assign frame_o     = frame_q;
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2
  import uart_rx_buf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t din_i,
  input  logic      pop_i,
  input  logic      clr_ovr_i,
  output logic      head_v_o,
  output rx_entry_t head_o,
  output logic      ovr_o
);
  rx_entry_t head_q, back_q;
  logic      head_v, back_v, ovr_q;
  logic      pop, full, acc;

  assign pop  = pop_i && head_v;
  assign full = head_v && back_v;
  assign acc  = push_i && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      back_q <= '0;
      head_v <= 1'b0;
      back_v <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (clr_ovr_i)          ovr_q <= 1'b0;
      else if (push_i && full) ovr_q <= 1'b1;

      if (pop) begin
        if (back_v) begin
          head_q <= back_q;
          back_v <= acc;
          if (acc) back_q <= din_i;
        end else begin
          head_v <= acc;
          if (acc) head_q <= din_i;
        end
      end else if (acc) begin
        if (!head_v) begin
          head_v <= 1'b1;
          head_q <= din_i;
        end else begin
          back_v <= 1'b1;
          back_q <= din_i;
        end
      end
    end
  end

  assign head_v_o = head_v;
  assign head_o   = head_v ? head_q : '0;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_buf_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_i,
  input  logic              rd_i,
  output logic              avail_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  localparam int PH_W = $clog2(OSR);

  logic [1:0]      sync_q;
  logic            rxd, tick, vote, idle, frame_vld;
  logic [PH_W-1:0] phase;
  rx_entry_t       frame, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rxd = sync_q[1];

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!rx_en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  rx_vote #(.OSR(OSR), .PH_W(PH_W)) u_vote (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (idle),
    .tick_i  (tick),
    .phase_i (phase),
    .din_i   (rxd),
    .vote_o  (vote)
  );

  rx_frame_fsm #(.OSR(OSR), .PH_W(PH_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rx_en_i),
    .tick_i      (tick),
    .rxd_i       (rxd),
    .nine_i      (nine_bit_i),
    .vote_i      (vote),
    .phase_o     (phase),
    .idle_o      (idle),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  rx_fifo2 u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (frame_vld && rx_en_i),
    .din_i     (frame),
    .pop_i     (rd_i),
    .clr_ovr_i (!rx_en_i),
    .head_v_o  (avail_o),
    .head_o    (head),
    .ovr_o     (ovr_o)
  );

  assign data_o = head.data;
  assign bit9_o = head.bit9;
  assign ferr_o = head.ferr;
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       rd_i,
  input logic       avail_o,
  input logic [7:0] data_o,
  input logic       bit9_o,
  input logic       ferr_o,
  input logic       ovr_o
);
  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && rx_en_i) |=> ovr_o);

  a_r9_ovr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !ovr_o);

  a_r9_no_entry_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !avail_o) |=> !avail_o);

  a_r8_ovr_needs_entries: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> avail_o);

  a_r6_avail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !rd_i) |=> avail_o);

  a_r6_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !rd_i) |=> ($stable(data_o) && $stable(bit9_o) && $stable(ferr_o)));
endmodule

bind uart_rx_buf uart_rx_buf_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rx_en_i (rx_en_i),
  .rd_i    (rd_i),
  .avail_o (avail_o),
  .data_o  (data_o),
  .bit9_o  (bit9_o),
  .ferr_o  (ferr_o),
  .ovr_o   (ovr_o)
);

// File: tb/uart_rx_buf_test.sv
`timescale 1ns/1ps
module uart_rx_buf_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       nine_bit_i = 1'b0;
  logic [7:0] div_i = '0;
  logic       rx_i = 1'b1;
  logic       rd_i = 1'b0;
  logic       avail_o, bit9_o, ferr_o, ovr_o;
  logic [7:0] data_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  uart_rx_buf uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i),
    .div_i(div_i), .rx_i(rx_i), .rd_i(rd_i), .avail_o(avail_o),
    .data_o(data_o), .bit9_o(bit9_o), .ferr_o(ferr_o), .ovr_o(ovr_o)
  );

  // {div[1:0], nine, glitch, stop, data9[8:0]}
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 9'h0A5},
    {2'd0, 1'b0, 1'b1, 1'b1, 9'h13C},
    {2'd0, 1'b1, 1'b0, 1'b1, 9'h1C3},
    {2'd0, 1'b1, 1'b1, 1'b0, 9'h055},
    {2'd2, 1'b0, 1'b0, 1'b1, 9'h0F0},
    {2'd2, 1'b1, 1'b1, 1'b1, 9'h181},
    {2'd0, 1'b0, 1'b0, 1'b0, 9'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int p, input logic gl);
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      rx_i = (gl && c == p / 2) ? ~b : b;
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stop,
                            input int div, input logic gl);
    int p;
    p = 16 * (div + 1);
    send_bit(1'b0, p, 1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) send_bit(d[i], p, gl);
    send_bit(stop, p, 1'b0);
    @(negedge clk);
    rx_i = 1'b1;
  endtask

  task automatic pop;
    @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    idle(3);
    chk("R10 avail", avail_o, 0);
    chk("R10 ovr", ovr_o, 0);
    chk("R10 data", data_o, 0);
    chk("R10 bit9/ferr", {bit9_o, ferr_o}, 0);
    rst_ni = 1'b1;
    rx_en_i = 1'b1;
    idle(4);

    // R1 R2 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] dv;
      logic nine, gl, stp;
      logic [8:0] d;
      {dv, nine, gl, stp, d} = VEC[v];
      div_i = 8'(dv);
      nine_bit_i = nine;
      send_frame(d, nine, stp, int'(dv), gl);
      idle(20 * (int'(dv) + 1));
      chk("R6 avail after frame", avail_o, 1);
      chk("R1 R2 data", data_o, d[7:0]);
      chk("R4 bit9", bit9_o, nine & d[8]);
      chk("R5 ferr", ferr_o, !stp);
      pop();
      chk("R7 empty after pop", avail_o, 0);
    end
    div_i = '0;
    nine_bit_i = 1'b0;

    // R3 start glitch
    @(negedge clk); rx_i = 1'b0;
    idle(3);
    @(negedge clk); rx_i = 1'b1;
    idle(60);
    chk("R3 glitch rejected", avail_o, 0);

    // R7 read on empty is ignored
    pop();
    chk("R7 empty read avail", avail_o, 0);
    send_frame(9'h05A, 1'b0, 1'b1, 0, 1'b0);
    idle(20);
    chk("R7 frame after empty read", data_o, 8'h5A);
    pop();

    // R8 overrun with three frames
    send_frame(9'h011, 1'b0, 1'b1, 0, 1'b0);
    idle(8);
    send_frame(9'h022, 1'b0, 1'b0, 0, 1'b0);
    idle(8);
    chk("R8 no ovr at two", ovr_o, 0);
    send_frame(9'h033, 1'b0, 1'b1, 0, 1'b0);
    idle(20);
    chk("R8 ovr set", ovr_o, 1);
    chk("R8 head oldest", data_o, 8'h11);
    chk("R8 head ferr", ferr_o, 0);
    pop();
    chk("R7 second remains", avail_o, 1);
    chk("R8 second entry", data_o, 8'h22);
    chk("R5 second ferr", ferr_o, 1);
    chk("R9 ovr sticky", ovr_o, 1);
    pop();
    chk("R8 third discarded", avail_o, 0);

    // R9 enable toggle clears overrun; off ignores line; held entry kept
    send_frame(9'h0C7, 1'b0, 1'b1, 0, 1'b0);
    idle(20);
    @(negedge clk); rx_en_i = 1'b0;
    idle(2);
    chk("R9 ovr cleared", ovr_o, 0);
    chk("R9 entry kept", data_o, 8'hC7);
    pop();
    send_frame(9'h099, 1'b0, 1'b1, 0, 1'b0);
    idle(20);
    chk("R9 off ignores line", avail_o, 0);
    @(negedge clk); rx_en_i = 1'b1;
    idle(4);
    send_frame(9'h066, 1'b0, 1'b1, 0, 1'b0);
    idle(20);
    chk("R9 receive after enable", data_o, 8'h66);
    chk("R9 ovr stays clear", ovr_o, 0);
    pop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule